// File: doc/BRIEF.md
# Address Region Decoder with Boot-Window Remap

This block sits between a 32-bit processor bus and the memories and peripherals of a small controller. For every access it decides which of four regions the address falls in: the low boot window at address zero, on-chip SRAM, the flash array, or the peripheral register page at the top of the address space. It returns a one-hot region select, the offset of the access inside that region and the little-endian byte-lane enables. Any address outside the four regions, any misaligned access and any illegal window access raises a data-abort flag, and an aborted access selects nothing.

A one-bit control register in the register page chooses what the boot window shows. After reset the window aliases flash. Software sets the bit to alias SRAM, so that exception vectors and handlers run from RAM, and clears it to bring flash back. The window passes its address through unchanged as the offset, so a window access reaches the same word of the array underneath as a direct access would. The decode is combinational and only the control bit is stored.

Top module: `memmap_decoder`

## Requirements
- R1: With `bus_valid` high and no abort, `sel` is one-hot: bit 0 for the boot window (0x0000_0000 to 0x0000_7FFF), bit 1 for SRAM (0x0004_0000 to 0x0004_17FF, 6 kB), bit 2 for flash (0x0008_0000 to 0x0008_7FFF) and bit 3 for the register page (0xFFFF_0000 to 0xFFFF_0FFF).
- R2: An access to an address outside all four regions asserts `abort` in the same cycle and drives `sel`, `offset` and `byte_en` to zero.
- R3: `offset` equals the address minus the base of the selected region; for the boot window it equals the address itself.
- R4: `bus_size` encodes 0 = byte, 1 = halfword, 2 = word. Byte lanes are little endian: a byte access enables lane `bus_addr[1:0]` only, a halfword enables lanes `bus_addr[1:0]` and `bus_addr[1:0]`+1, a word enables all four (`byte_en` = 4'hF).
- R5: A halfword with `bus_addr[0]` set, a word with `bus_addr[1:0]` not zero, or `bus_size` = 3 raises `abort`.
- R6: After reset the remap bit `win_sram` is 0 and the window maps to flash.
- R7: A write at 0xFFFF_0220 that enables lane 0 loads `bus_wdata[0]` into the remap bit at the clock edge that ends the access; the access itself decodes under the old mapping. A read of that word returns the bit on `ctl_rdata[0]`; writes that leave lane 0 disabled do not change it.
- R8: While `win_sram` is 0 the window reaches flash and any write to it aborts; while it is 1 the window reaches SRAM, writes are allowed, and window addresses at or beyond the SRAM size (0x1800) abort.
- R9: With `bus_valid` low the block asserts no select, no lane enable and no abort, and the remap bit is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_size | input | 2 | Access size code (0 byte, 1 half, 2 word) |
| bus_wdata | input | 32 | Write data, little-endian lanes |
| sel | output | 4 | One-hot region select (window, SRAM, flash, registers) |
| offset | output | 17 | Byte offset inside the selected region |
| byte_en | output | 4 | Byte-lane enables |
| abort | output | 1 | Data abort for this access |
| win_sram | output | 1 | Remap bit: 1 = window shows SRAM |
| ctl_rdata | output | 32 | Read data of the remap control word |

## Verification
Select, offset, lane enables, abort and read data are combinational, so each is due in the same cycle as the access; the remap bit changes at the clock edge that ends a control write and is first seen by the following access. The bench drives each access at a falling edge, queues the values expected for that cycle, and its monitor compares them a quarter period later, before the next rising edge. Expectations for the window follow the remap state the bench itself tracks from its own writes, so the cycle of the control write is checked under the old mapping and the next one under the new.

// File: rtl/memmap_pkg.sv
// Shared encodings for the address region decoder.
// Assumes a 32-bit byte-addressed bus with four byte lanes.
package memmap_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam int N_REGIONS = 4;
    localparam int RG_WIN    = 0;
    localparam int RG_SRAM   = 1;
    localparam int RG_FLASH  = 2;
    localparam int RG_REGS   = 3;
endpackage

// File: rtl/mm_region_match.sv
// Compares an address against one region [BASE, BASE+SIZE) and returns
// the hit flag and the offset from BASE. Assumes BASE+SIZE <= 2**32.
module mm_region_match #(
    parameter logic [31:0] BASE  = 32'h0,
    parameter logic [31:0] SIZE  = 32'h1000,
    parameter int          OFF_W = 17
) (
    input  logic [31:0]      addr,
    output logic             hit,
    output logic [OFF_W-1:0] off
);
    localparam logic [32:0] LIMIT = {1'b0, BASE} + {1'b0, SIZE};

    logic [31:0] diff;

    // range compare done in 33 bits so the top region cannot wrap
    always_comb begin
        diff = addr - BASE;
        hit  = ({1'b0, addr} >= {1'b0, BASE}) && ({1'b0, addr} < LIMIT);
        off  = diff[OFF_W-1:0];
    end

    logic unused_diff;
    assign unused_diff = ^diff[31:OFF_W];
endmodule

// File: rtl/mm_lane_gen.sv
// Turns size code and low address bits into little-endian byte-lane
// enables and flags misaligned or reserved-size accesses.
module mm_lane_gen
    import memmap_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  logic [1:0] size,
    output logic [3:0] lanes,
    output logic       bad_align
);
    // lane pattern per size; lowest address lands on lane 0
    always_comb begin
        lanes     = 4'h0;
        bad_align = 1'b0;
        unique case (acc_size_e'(size))
            SZ_BYTE: lanes = 4'b0001 << addr_lo;
            SZ_HALF: begin
                lanes     = 4'b0011 << addr_lo;
                bad_align = addr_lo[0];
            end
            SZ_WORD: begin
                lanes     = 4'hF;
                bad_align = (addr_lo != 2'b00);
            end
            default: bad_align = 1'b1;
        endcase
    end
endmodule

// File: rtl/mm_remap_reg.sv
// One-bit boot-window remap control. Loads on a qualified write,
// clears on synchronous active-low reset.
module mm_remap_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic d,
    output logic q
);
    // hold the window mapping between control writes
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 1'b0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/memmap_decoder.sv
// Address region decoder with a remappable boot window.
// Decode is combinational; only the remap bit is stored, so a control
// write changes the mapping from the next access on. Assumes regions are
// listed in ascending address order and the window starts at zero.
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter logic [31:0] WIN_BYTES   = 32'h0000_8000,
    parameter logic [31:0] SRAM_BASE   = 32'h0004_0000,
    parameter logic [31:0] SRAM_BYTES  = 32'h0000_1800,
    parameter logic [31:0] FLASH_BASE  = 32'h0008_0000,
    parameter logic [31:0] FLASH_BYTES = 32'h0000_8000,
    parameter logic [31:0] REGS_BASE   = 32'hFFFF_0000,
    parameter logic [31:0] REGS_BYTES  = 32'h0000_1000,
    parameter logic [31:0] CTL_ADDR    = 32'hFFFF_0220,
    parameter int          OFF_W       = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [31:0]      bus_addr,
    input  logic [1:0]       bus_size,
    input  logic [31:0]      bus_wdata,
    output logic [3:0]       sel,
    output logic [OFF_W-1:0] offset,
    output logic [3:0]       byte_en,
    output logic             abort,
    output logic             win_sram,
    output logic [31:0]      ctl_rdata
);
    localparam logic [31:0] WIN_TO_FLASH = (FLASH_BYTES < WIN_BYTES) ? FLASH_BYTES : WIN_BYTES;
    localparam logic [31:0] WIN_TO_SRAM  = (SRAM_BYTES  < WIN_BYTES) ? SRAM_BYTES  : WIN_BYTES;
    localparam logic [31:0] CTL_REL      = CTL_ADDR - REGS_BASE;
    localparam logic [OFF_W-3:0] CTL_WORD = CTL_REL[OFF_W-1:2];
    localparam logic [31:0] MAX_SPAN     = 32'd1 << OFF_W;

    // elaboration-time layout checks
    if (WIN_BYTES > SRAM_BASE || SRAM_BASE + SRAM_BYTES > FLASH_BASE ||
        FLASH_BASE + FLASH_BYTES > REGS_BASE) begin : g_overlap
        $error("memmap_decoder: regions overlap or are out of order");
    end
    if (WIN_BYTES > MAX_SPAN || SRAM_BYTES > MAX_SPAN ||
        FLASH_BYTES > MAX_SPAN || REGS_BYTES > MAX_SPAN) begin : g_offw
        $error("memmap_decoder: OFF_W too narrow for a region");
    end

    function automatic logic [31:0] rg_base(input int idx);
        case (idx)
            RG_WIN:   return 32'h0;
            RG_SRAM:  return SRAM_BASE;
            RG_FLASH: return FLASH_BASE;
            default:  return REGS_BASE;
        endcase
    endfunction

    function automatic logic [31:0] rg_size(input int idx);
        case (idx)
            RG_WIN:   return WIN_BYTES;
            RG_SRAM:  return SRAM_BYTES;
            RG_FLASH: return FLASH_BYTES;
            default:  return REGS_BYTES;
        endcase
    endfunction

    logic [N_REGIONS-1:0] hit;
    logic [OFF_W-1:0]     rg_off [N_REGIONS];
    logic [3:0]           lanes;
    logic                 bad_align;
    logic                 win_oob;
    logic                 win_ro;
    logic                 is_ctl;
    logic                 ctl_load;

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_region
        mm_region_match #(
            .BASE  (rg_base(g)),
            .SIZE  (rg_size(g)),
            .OFF_W (OFF_W)
        ) u_match (
            .addr (bus_addr),
            .hit  (hit[g]),
            .off  (rg_off[g])
        );
    end

    mm_lane_gen u_lanes (
        .addr_lo   (bus_addr[1:0]),
        .size      (bus_size),
        .lanes     (lanes),
        .bad_align (bad_align)
    );

    mm_remap_reg u_remap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ctl_load),
        .d     (bus_wdata[0]),
        .q     (win_sram)
    );

    // window legality under the current mapping
    always_comb begin
        win_oob = hit[RG_WIN] && (bus_addr >= (win_sram ? WIN_TO_SRAM : WIN_TO_FLASH));
        win_ro  = hit[RG_WIN] && bus_write && !win_sram;
    end

    // abort, one-hot select and lane gating
    always_comb begin
        abort   = bus_valid && ((hit == '0) || bad_align || win_oob || win_ro);
        sel     = (bus_valid && !abort) ? hit : '0;
        byte_en = (sel != '0) ? lanes : 4'h0;
    end

    // offset of the selected region, zero when nothing is selected
    always_comb begin
        offset = '0;
        for (int i = 0; i < N_REGIONS; i++) begin
            if (sel[i]) offset = offset | rg_off[i];
        end
    end

    // control-word hit and remap load strobe
    always_comb begin
        is_ctl    = sel[RG_REGS] && (offset[OFF_W-1:2] == CTL_WORD);
        ctl_load  = is_ctl && bus_write && byte_en[0];
        ctl_rdata = (is_ctl && !bus_write) ? {31'b0, win_sram} : 32'h0;
    end

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata[31:1];
endmodule

// File: rtl/memmap_decoder_chk.sv
// Temporal checks on the region decoder, attached by bind.
// Assumes the default control address 0xFFFF_0220.
module memmap_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [31:0] bus_addr,
    input logic [1:0]  bus_size,
    input logic        wr_bit,
    input logic [3:0]  sel,
    input logic [16:0] offset,
    input logic [3:0]  byte_en,
    input logic        abort,
    input logic        win_sram
);
    logic ctl_wr;
    assign ctl_wr = bus_valid && bus_write && sel[3] &&
                    (bus_addr[31:2] == 30'h3FFF_C088) && byte_en[0];

    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    p_abort_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (sel == 4'h0 && byte_en == 4'h0 && offset == 17'h0));

    p_word_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != 4'h0 && bus_size == 2'd2) |-> byte_en == 4'hF);

    p_half_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_size == 2'd1 && bus_addr[0]) |-> abort);

    p_remap_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (win_sram == $past(wr_bit)));

    p_remap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(win_sram));

    p_win_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[0] && bus_write) |-> win_sram);

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (sel == 4'h0 && byte_en == 4'h0 && !abort));
endmodule

bind memmap_decoder memmap_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .wr_bit    (bus_wdata[0]),
    .sel       (sel),
    .offset    (offset),
    .byte_en   (byte_en),
    .abort     (abort),
    .win_sram  (win_sram)
);

// File: tb/memmap_decoder_tb.sv
// Scoreboard bench: the driver queues the expected decode of each access,
// the monitor compares it a quarter period after the driving edge.
module memmap_decoder_tb;
    localparam int T = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  sel;
    logic [16:0] offset;
    logic [3:0]  byte_en;
    logic        abort;
    logic        win_sram;
    logic [31:0] ctl_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0]  sel;
        logic [16:0] off;
        logic [3:0]  be;
        logic        ab;
        logic        ws;
        logic [31:0] rd;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #(T/2) clk = ~clk;

    memmap_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .sel       (sel),
        .offset    (offset),
        .byte_en   (byte_en),
        .abort     (abort),
        .win_sram  (win_sram),
        .ctl_rdata (ctl_rdata)
    );

    task automatic acc(input logic v, input logic wr, input logic [31:0] a,
                       input logic [1:0] sz, input logic [31:0] wd,
                       input logic [3:0] e_sel, input logic [16:0] e_off,
                       input logic [3:0] e_be, input logic e_ab,
                       input logic e_ws, input logic [31:0] e_rd,
                       input string tag);
        exp_t e;
        @(negedge clk);
        bus_valid = v;
        bus_write = wr;
        bus_addr  = a;
        bus_size  = sz;
        bus_wdata = wd;
        e.sel = e_sel; e.off = e_off; e.be = e_be; e.ab = e_ab;
        e.ws = e_ws; e.rd = e_rd; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: pop and compare one item per cycle
    initial begin
        forever begin
            @(negedge clk);
            #(T/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (sel !== e.sel || offset !== e.off || byte_en !== e.be ||
                    abort !== e.ab || win_sram !== e.ws || ctl_rdata !== e.rd) begin
                    errors++;
                    $display("FAIL %s: got sel=%h off=%h be=%h ab=%b ws=%b rd=%h exp sel=%h off=%h be=%h ab=%b ws=%b rd=%h",
                             e.tag, sel, offset, byte_en, abort, win_sram, ctl_rdata,
                             e.sel, e.off, e.be, e.ab, e.ws, e.rd);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R6 R9: during reset, idle
        acc(0, 0, 32'h0, 2'd2, 0, 4'h0, 0, 4'h0, 0, 0, 0, "R6 in reset");
        rst_n = 1'b1;
        acc(0, 0, 32'h0, 2'd2, 0, 4'h0, 0, 4'h0, 0, 0, 0, "R6 after reset");
        // R1 R3 window to flash
        acc(1, 0, 32'h0000_0000, 2'd2, 0, 4'h1, 17'h0,    4'hF, 0, 0, 0, "R1 window base");
        acc(1, 0, 32'h0000_7FFC, 2'd2, 0, 4'h1, 17'h7FFC, 4'hF, 0, 0, 0, "R3 window top");
        acc(1, 0, 32'h0000_8000, 2'd2, 0, 4'h0, 17'h0,    4'h0, 1, 0, 0, "R2 gap above window");
        // R4 lanes in SRAM
        acc(1, 0, 32'h0004_0003, 2'd0, 0, 4'h2, 17'h3,    4'h8, 0, 0, 0, "R4 byte lane 3");
        acc(1, 0, 32'h0004_0006, 2'd1, 0, 4'h2, 17'h6,    4'hC, 0, 0, 0, "R4 upper half");
        acc(1, 1, 32'h0004_17FC, 2'd2, 32'hA5, 4'h2, 17'h17FC, 4'hF, 0, 0, 0, "R3 SRAM last word");
        acc(1, 0, 32'h0004_1800, 2'd2, 0, 4'h0, 17'h0,    4'h0, 1, 0, 0, "R2 past SRAM");
        acc(1, 0, 32'h0008_0010, 2'd2, 0, 4'h4, 17'h10,   4'hF, 0, 0, 0, "R1 flash");
        acc(1, 0, 32'h0008_7FFF, 2'd0, 0, 4'h4, 17'h7FFF, 4'h8, 0, 0, 0, "R1 flash last byte");
        acc(1, 0, 32'h0008_8000, 2'd2, 0, 4'h0, 17'h0,    4'h0, 1, 0, 0, "R2 past flash");
        acc(1, 0, 32'hFFFF_0FFC, 2'd2, 0, 4'h8, 17'hFFC,  4'hF, 0, 0, 0, "R1 register top");
        acc(1, 0, 32'hFFFF_1000, 2'd2, 0, 4'h0, 17'h0,    4'h0, 1, 0, 0, "R2 past registers");
        // R5 alignment
        acc(1, 0, 32'h0004_0001, 2'd1, 0, 4'h0, 17'h0, 4'h0, 1, 0, 0, "R5 odd halfword");
        acc(1, 0, 32'h0004_0002, 2'd2, 0, 4'h0, 17'h0, 4'h0, 1, 0, 0, "R5 unaligned word");
        acc(1, 0, 32'h0004_0000, 2'd3, 0, 4'h0, 17'h0, 4'h0, 1, 0, 0, "R5 reserved size");
        // R8 flash window is read-only
        acc(1, 1, 32'h0000_0010, 2'd2, 0, 4'h0, 17'h0, 4'h0, 1, 0, 0, "R8 write flash window");
        // R7 remap control
        acc(1, 0, 32'hFFFF_0220, 2'd2, 0, 4'h8, 17'h220, 4'hF, 0, 0, 0, "R7 readback 0");
        acc(1, 1, 32'hFFFF_0220, 2'd2, 32'h1, 4'h8, 17'h220, 4'hF, 0, 0, 0, "R7 write uses old map");
        acc(1, 0, 32'h0000_0000, 2'd2, 0, 4'h1, 17'h0, 4'hF, 0, 1, 0, "R8 window now SRAM");
        acc(1, 0, 32'hFFFF_0220, 2'd2, 0, 4'h8, 17'h220, 4'hF, 0, 1, 32'h1, "R7 readback 1");
        acc(1, 1, 32'h0000_0010, 2'd2, 0, 4'h1, 17'h10, 4'hF, 0, 1, 0, "R8 write SRAM window");
        acc(1, 0, 32'h0000_17FC, 2'd2, 0, 4'h1, 17'h17FC, 4'hF, 0, 1, 0, "R8 SRAM window top");
        acc(1, 0, 32'h0000_1800, 2'd2, 0, 4'h0, 17'h0, 4'h0, 1, 1, 0, "R8 beyond SRAM size");
        // R9 idle does nothing even on a control address
        acc(0, 1, 32'hFFFF_0220, 2'd2, 32'h0, 4'h0, 17'h0, 4'h0, 0, 1, 0, "R9 idle write");
        acc(0, 0, 32'h0000_0000, 2'd2, 0, 4'h0, 17'h0, 4'h0, 0, 1, 0, "R9 bit kept");
        // R7 byte write on lane 1 leaves bit alone
        acc(1, 1, 32'hFFFF_0221, 2'd0, 32'h0, 4'h8, 17'h221, 4'h2, 0, 1, 0, "R7 lane1 write");
        acc(1, 0, 32'h0000_0000, 2'd2, 0, 4'h1, 17'h0, 4'hF, 0, 1, 0, "R7 lane1 no effect");
        acc(1, 1, 32'hFFFF_0220, 2'd0, 32'h0, 4'h8, 17'h220, 4'h1, 0, 1, 0, "R7 byte clear");
        acc(1, 0, 32'h0000_1800, 2'd2, 0, 4'h1, 17'h1800, 4'hF, 0, 0, 0, "R8 flash back");
        acc(0, 0, 32'h0, 2'd2, 0, 4'h0, 0, 4'h0, 0, 0, 0, "R9 final idle");
        @(negedge clk);
        #(T/2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule